// File: doc/BRIEF.md
# Conversion Start and Power-Down Sequencer

This block is the control state machine of a sampling converter. It takes the decoded fields of the control register, captured on a write-done pulse, and a conversion-start pin. It produces a busy flag, a one-cycle end-of-conversion pulse, a two-bit power state and an enable for the on-chip reference. The serial shifting that produces the field values and the analog circuits that act on the outputs are outside this block.

A conversion starts in one of two ways. The first is a register write with the software start bit set, which waits a fixed settling delay and then converts. The delay lets a channel change and a start share one write. The second is a rising edge on the start pin, which converts at once. Both durations are clock counts set by parameters; the defaults suit a 100 MHz clock, giving 400 ns and 2.3 µs. A two-bit power mode chooses what happens after each conversion: drop to partial power-down, drop to full power-down, or stay up. The fourth mode value forces full power-down at once, aborts any conversion and blocks all starts. The reference enable follows the external-reference bit and the power state.

Top module: `convstart_pwr_seq`

## Requirements
- R1: After reset, power_state is 2'b00 (off), busy, eoc, ref_en and sw_start_flag are all 0, and the latched power mode is 2'b00.
- R2: A write with sw_start=1 and mode 2'b01, 2'b10 or 2'b11 while idle makes busy high from the next cycle for exactly SETTLE_CYC+CONV_CYC cycles. eoc is then high for exactly one cycle with busy low.
- R3: A rising edge on hw_start while idle, with the latched mode not 2'b00, makes busy high from the next cycle for exactly CONV_CYC cycles, followed by one eoc cycle. Holding hw_start high starts no further conversion.
- R4: sw_start_flag is high from the cycle after an accepted software start and is low in the eoc cycle.
- R5: In the cycle after eoc, power_state becomes 2'b01 (partial) for mode 2'b01, 2'b00 (off) for mode 2'b10 and 2'b10 (on) for mode 2'b11.
- R6: From the cycle after a start is accepted, power_state is 2'b10 (on) until the conversion ends.
- R7: A write with mode 2'b00 makes power_state 2'b00 and clears busy and sw_start_flag in the next cycle, even in mid-conversion, and no eoc follows. While mode 2'b00 is latched, software and pin starts are ignored.
- R8: A write with mode 2'b11 makes power_state 2'b10 in the next cycle. A write with mode 2'b01 or 2'b10 and sw_start=0 while idle leaves power_state unchanged.
- R9: A software start or hw_start edge that arrives while busy or eoc is high is ignored: the running conversion keeps its length and produces one eoc.
- R10: ref_en is high exactly when the latched ext_ref bit is 0 and power_state is not 2'b00. A write updates it in the next cycle.
- R11: A write with mode 2'b01, 2'b10 or 2'b11 during a conversion does not disturb it, and the newly written mode decides the state after eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_done | input | 1 | One-cycle pulse: the cfg_* fields below hold a newly written control word |
| cfg_pwr_mode | input | 2 | Power mode field of the written word |
| cfg_sw_start | input | 1 | Software start bit of the written word |
| cfg_ext_ref | input | 1 | External reference select of the written word |
| hw_start | input | 1 | Conversion-start pin; a rising edge requests a conversion |
| busy | output | 1 | High during the settling delay and the conversion |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| power_state | output | 2 | 00 off, 01 partial, 10 on |
| ref_en | output | 1 | Enable for the on-chip reference |
| sw_start_flag | output | 1 | Latched software start bit; clears itself at end of conversion |

## Verification
Every result is counted from the clock edge that samples the stimulus. The power state, the flag and the reference enable are due one edge after the write. Busy covers SETTLE_CYC+CONV_CYC cycles for a software start and CONV_CYC cycles for a pin start. eoc comes in the cycle right after busy falls, and the end-of-conversion power state comes one cycle after eoc. Inputs are driven and outputs sampled on the falling clock edge, and the busy run is measured by counting sampled cycles. This gives exact cycle counts, compared with the parameter sums, rather than a wait for an event with a timeout.

// File: rtl/convstart_pwr_pkg.sv
package convstart_pwr_pkg;

    typedef enum logic [1:0] {
        PM_FORCE_OFF = 2'b00,
        PM_AUTO_PART = 2'b01,
        PM_AUTO_OFF  = 2'b10,
        PM_STAY_ON   = 2'b11
    } pwr_mode_t;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_PART = 2'b01,
        PWR_ON   = 2'b10
    } pwr_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'b00,
        SQ_SETTLE = 2'b01,
        SQ_CONV   = 2'b10,
        SQ_DONE   = 2'b11
    } seq_state_t;

    typedef struct packed {
        pwr_mode_t mode;
        logic      start;
        logic      ext_ref;
    } ctrl_word_t;

    function automatic pwr_state_t after_conv(input pwr_mode_t m);
        case (m)
            PM_AUTO_PART: after_conv = PWR_PART;
            PM_STAY_ON:   after_conv = PWR_ON;
            default:      after_conv = PWR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/convstart_edge_det.sv
module convstart_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
endmodule

// File: rtl/convstart_down_timer.sv
module convstart_down_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // a load always leaves a nonzero or zero count that then only falls
    assert_count_falls_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/convstart_pwr_ctl.sv
module convstart_pwr_ctl
    import convstart_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       force_off,
    input  logic       force_on,
    input  logic       conv_go,
    input  logic       conv_end,
    input  pwr_mode_t  mode_q,
    output pwr_state_t pwr
);
    always_ff @(posedge clk) begin
        if (rst)            pwr <= PWR_OFF;
        else if (force_off) pwr <= PWR_OFF;
        else if (force_on)  pwr <= PWR_ON;
        else if (conv_end)  pwr <= after_conv(mode_q);
        else if (conv_go)   pwr <= PWR_ON;
    end

    assert_force_off_R7: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (pwr == PWR_OFF));

    assert_partial_end_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_end && !force_off && !force_on && mode_q == PM_AUTO_PART) |=> (pwr == PWR_PART));

    assert_stay_on_R8: assert property (@(posedge clk) disable iff (rst)
        (force_on && !force_off) |=> (pwr == PWR_ON));
endmodule

// File: rtl/convstart_pwr_seq.sv
module convstart_pwr_seq
    import convstart_pwr_pkg::*;
#(
    parameter int SETTLE_CYC = 40,
    parameter int CONV_CYC   = 230
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr_done,
    input  logic [1:0] cfg_pwr_mode,
    input  logic       cfg_sw_start,
    input  logic       cfg_ext_ref,
    input  logic       hw_start,
    output logic       busy,
    output logic       eoc,
    output logic [1:0] power_state,
    output logic       ref_en,
    output logic       sw_start_flag
);
    localparam int MAX_CYC = (SETTLE_CYC > CONV_CYC) ? SETTLE_CYC : CONV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD   = CNT_W'(CONV_CYC - 1);

    ctrl_word_t wr_word;
    ctrl_word_t ctl_q;
    seq_state_t st;
    pwr_state_t pwr;
    logic       hw_rise;
    logic       t_zero;
    logic       t_load;
    logic [CNT_W-1:0] t_val;
    logic       force_off, force_on, acc_sw, acc_hw, conv_last;

    assign wr_word = '{mode: pwr_mode_t'(cfg_pwr_mode), start: cfg_sw_start, ext_ref: cfg_ext_ref};

    convstart_edge_det u_edge (
        .clk (clk), .rst (rst), .pin (hw_start), .rise (hw_rise)
    );

    assign force_off = cfg_wr_done && (wr_word.mode == PM_FORCE_OFF);
    assign force_on  = cfg_wr_done && (wr_word.mode == PM_STAY_ON);
    assign acc_sw    = cfg_wr_done && wr_word.start && (wr_word.mode != PM_FORCE_OFF)
                       && (st == SQ_IDLE);
    assign acc_hw    = hw_rise && !cfg_wr_done && (ctl_q.mode != PM_FORCE_OFF)
                       && (st == SQ_IDLE);
    assign conv_last = (st == SQ_CONV) && t_zero;

    always_comb begin
        t_load = 1'b0;
        t_val  = CONV_LD;
        if (!force_off) begin
            if (acc_sw) begin
                t_load = 1'b1;
                t_val  = SETTLE_LD;
            end else if (acc_hw || (st == SQ_SETTLE && t_zero)) begin
                t_load = 1'b1;
            end
        end
    end

    convstart_down_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk), .rst (rst), .load (t_load), .load_val (t_val), .zero (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE;
        end else if (force_off) begin
            st <= SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE:   if (acc_sw) st <= SQ_SETTLE;
                           else if (acc_hw) st <= SQ_CONV;
                SQ_SETTLE: if (t_zero) st <= SQ_CONV;
                SQ_CONV:   if (t_zero) st <= SQ_DONE;
                default:   st <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mode: PM_FORCE_OFF, start: 1'b0, ext_ref: 1'b0};
        end else begin
            if (cfg_wr_done) begin
                ctl_q.mode    <= wr_word.mode;
                ctl_q.ext_ref <= wr_word.ext_ref;
            end
            if (force_off || conv_last) ctl_q.start <= 1'b0;
            else if (acc_sw)            ctl_q.start <= 1'b1;
        end
    end

    convstart_pwr_ctl u_pwr (
        .clk       (clk),
        .rst       (rst),
        .force_off (force_off),
        .force_on  (force_on),
        .conv_go   (acc_sw || acc_hw),
        .conv_end  (st == SQ_DONE),
        .mode_q    (ctl_q.mode),
        .pwr       (pwr)
    );

    assign busy          = (st == SQ_SETTLE) || (st == SQ_CONV);
    assign eoc           = (st == SQ_DONE);
    assign power_state   = pwr;
    assign ref_en        = !ctl_q.ext_ref && (pwr != PWR_OFF);
    assign sw_start_flag = ctl_q.start;

    assert_eoc_single_R2: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    assert_eoc_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !(eoc && busy));

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
        eoc |-> !sw_start_flag);

    assert_busy_on_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (power_state == 2'b10));

    assert_ext_ref_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_done && cfg_ext_ref) |=> !ref_en);

    assert_pwr_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (power_state != $past(power_state)) |->
            ($past(cfg_wr_done) || $past(eoc) || $past(hw_start)));
endmodule

// File: tb/convstart_pwr_seq_tb.sv
module convstart_pwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D = 3;
    localparam int C = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sws = 1'b0;
    logic ext = 1'b0;
    logic hw = 1'b0;
    logic busy, eoc, ref_en, flag;
    logic [1:0] pwr;

    int checks = 0;
    int fails = 0;
    int nb = 0;
    int ne = 0;
    bit cnt_en = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    convstart_pwr_seq #(.SETTLE_CYC(D), .CONV_CYC(C)) dut_i (
        .clk (clk), .rst (rst), .cfg_wr_done (wr), .cfg_pwr_mode (mode),
        .cfg_sw_start (sws), .cfg_ext_ref (ext), .hw_start (hw),
        .busy (busy), .eoc (eoc), .power_state (pwr), .ref_en (ref_en),
        .sw_start_flag (flag)
    );

    always @(negedge clk) if (cnt_en) begin
        nb += int'(busy);
        ne += int'(eoc);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int end_pwr(input int m);
        if (m == 1) return 1;
        if (m == 3) return 2;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr = 1'b0; hw = 1'b0; sws = 1'b0; ext = 1'b0; mode = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input int m, input bit s, input bit e);
        @(negedge clk);
        mode = 2'(m); sws = s; ext = e; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; sws = 1'b0;
    endtask

    task automatic run_to_eoc(output int n);
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        int n;
        // R1 reset state
        do_reset();
        check("R1 pwr", pwr, 0);
        check("R1 busy", busy, 0);
        check("R1 eoc", eoc, 0);
        check("R1 ref_en", ref_en, 0);
        check("R1 flag", flag, 0);

        // R7 pin start ignored while reset mode 00 latched
        @(negedge clk); hw = 1'b1;
        @(negedge clk); hw = 1'b0;
        check("R7 hw ignored busy", busy, 0);
        do_write(0, 1'b1, 1'b0);
        check("R7 sw ignored busy", busy, 0);
        check("R7 sw ignored flag", flag, 0);

        // R2 R4 R5 R6 R10 software start sweep over modes and reference select
        for (int m = 1; m <= 3; m++) begin
            for (int e = 0; e <= 1; e++) begin
                do_reset();
                do_write(m, 1'b1, e[0]);
                check("R6 pwr on at start", pwr, 2);
                check("R4 flag set", flag, 1);
                check("R10 ref during conv", ref_en, (e == 0) ? 1 : 0);
                run_to_eoc(n);
                check("R2 busy length", n, D + C);
                check("R2 eoc pulse", eoc, 1);
                check("R4 flag clear at eoc", flag, 0);
                @(negedge clk);
                check("R2 eoc single", eoc, 0);
                check("R5 end state", pwr, end_pwr(m));
                check("R10 ref after end", ref_en, (e == 0 && end_pwr(m) != 0) ? 1 : 0);
            end
        end

        // R3 R8 pin start sweep
        for (int m = 1; m <= 3; m++) begin
            do_reset();
            do_write(m, 1'b0, 1'b0);
            check("R8 pwr after mode write", pwr, (m == 3) ? 2 : 0);
            @(negedge clk); hw = 1'b1;
            @(negedge clk);
            check("R3 busy after edge", busy, 1);
            check("R6 pwr on after edge", pwr, 2);
            check("R4 flag untouched by pin", flag, 0);
            run_to_eoc(n);
            check("R3 busy length", n, C);
            check("R3 eoc", eoc, 1);
            @(negedge clk);
            check("R5 end state pin", pwr, end_pwr(m));
            nb = 0; cnt_en = 1'b1;
            repeat (D + C + 2) @(negedge clk);
            cnt_en = 1'b0;
            check("R3 level no restart", nb, 0);
            hw = 1'b0;
        end

        // R7 abort in mid-conversion
        do_reset();
        do_write(3, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        do_write(0, 1'b0, 1'b0);
        check("R7 abort busy", busy, 0);
        check("R7 abort pwr", pwr, 0);
        check("R7 abort flag", flag, 0);
        check("R10 ref off when powered off", ref_en, 0);
        ne = 0; cnt_en = 1'b1;
        repeat (D + C + 3) @(negedge clk);
        cnt_en = 1'b0;
        check("R7 no eoc after abort", ne, 0);

        // R9 starts while busy ignored
        do_reset();
        nb = 0; ne = 0; cnt_en = 1'b1;
        do_write(2, 1'b1, 1'b0);
        hw = 1'b1;
        @(negedge clk); hw = 1'b0;
        do_write(2, 1'b1, 1'b0);
        repeat (D + C + 4) @(negedge clk);
        cnt_en = 1'b0;
        check("R9 busy length unchanged", nb, D + C);
        check("R9 single eoc", ne, 1);
        check("R5 auto off", pwr, 0);

        // R11 mode rewritten during conversion decides end state
        do_reset();
        do_write(1, 1'b1, 1'b0);
        @(negedge clk);
        do_write(3, 1'b0, 1'b0);
        check("R11 still busy", busy, 1);
        run_to_eoc(n);
        check("R11 total busy", n + 3, D + C);
        @(negedge clk);
        check("R11 end state from new mode", pwr, 2);

        // R10 R8 reference select and idle mode writes
        do_write(3, 1'b0, 1'b1);
        check("R10 ext ref disables", ref_en, 0);
        check("R8 stay on", pwr, 2);
        do_write(3, 1'b0, 1'b0);
        check("R10 internal ref enabled", ref_en, 1);
        do_write(1, 1'b0, 1'b0);
        check("R8 idle auto write keeps pwr", pwr, 2);
        do_write(2, 1'b0, 1'b0);
        check("R8 idle auto-off write keeps pwr", pwr, 2);

        done = 1'b1;
        report();
    end
endmodule